// File: doc/BRIEF.md
# Display Command Decoder with Pin Override

This block sits behind a host command link and watches the stream of bytes it delivers. It picks out one display-control command made of a head byte and an optional tail byte. The head byte carries a fixed identifier in its upper nibble. For each of two general-purpose output pins it also carries a source-select bit and a level bit. A pin whose select bit is clear follows an internal function signal. A pin whose select bit is set is held at the level bit.

The tail byte is marked by a clear top bit. It carries five setup flags for the display timing logic: the sync edge polarity, the separation time, the mask release, the mask length and the border mode. The block latches these flags, but only when the tail byte arrives as the next valid byte after an accepted head. Any other head-type byte cancels that expectation. The output pins can be driven straight from the multiplexer, or through an output register that adds one cycle.

Top module: `disp_ctl_cmd`

## Requirements
- R1: Reset (rst_n low) clears the pin-control state, the setup flags and the tail expectation. Afterwards each pin follows its function input, setup_o reads 0, and the registered-output variant drives its pins low.
- R2: A valid byte whose bits 7:4 equal 1111 is a head. Bits 3 and 2 are the select and level for pin A, which is pin_o[1]. Bits 1 and 0 are the select and level for pin B, which is pin_o[0]. The head takes effect on the pins only after the clock edge that accepts it.
- R3: When a pin's select bit is 0, the pin follows its function input combinationally, whatever the level bit holds.
- R4: When a pin's select bit is 1, the pin drives its level bit (0 gives low, 1 gives high) and ignores its function input.
- R5: A valid byte with bit 7 equal to 0, arriving as the next valid byte after an accepted head, loads its bits 4:0 into setup_o. Bits 6:5 of that byte are ignored.
- R6: A valid byte with bit 7 equal to 0 that arrives while no head is pending changes neither setup_o nor the pins.
- R7: A valid byte with bit 7 equal to 1 and an identifier other than 1111 leaves the pins untouched and cancels a pending tail. The next bit-7-clear byte is then ignored.
- R8: Each head admits at most one tail. A second bit-7-clear byte after a consumed tail is ignored.
- R9: Cycles with byte_vld_i low change no state, whatever byte_i holds. A pending tail stays pending across such cycles.
- R10: With PIN_REG_OUT=1, each pin shows the multiplexer result of the previous cycle. That is one cycle later than with PIN_REG_OUT=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| byte_vld_i | input | 1 | byte_i holds a byte from the command link this cycle |
| byte_i | input | BYTE_W | Command byte |
| func_i | input | NUM_PINS | Internal function signal for each pin (bit 1 = pin A, bit 0 = pin B) |
| pin_o | output | NUM_PINS | Multiplexed output pins (bit 1 = pin A, bit 0 = pin B) |
| setup_o | output | SETUP_W | Latched tail flags: 4 edge rising, 3 long separation, 2 mask released, 1 long mask, 0 two-level border |

## Verification
The bench builds two copies side by side with the default byte layout: 8-bit bytes, a 4-bit identifier, two pins and five setup flags. One copy has PIN_REG_OUT=0 and the other has PIN_REG_OUT=1, so the combinational and the registered pin paths run under the same stimulus. Every cycle is compared against the bench's reference model. Directed sequences cover the following cases:
- a tail with no head before it;
- a foreign head sitting between a head and its tail;
- repeated tails;
- idle gaps with junk on the data bus;
- a reset in the middle of the run.

A biased random byte stream then mixes heads, foreign heads and tails.

// File: rtl/disp_ctl_pkg.sv
package disp_ctl_pkg;

   typedef enum logic [0:0] {
      SEQ_IDLE  = 1'b0,
      SEQ_WAIT2 = 1'b1
   } seq_state_e;

   typedef enum logic [1:0] {
      BYTE_NONE      = 2'd0,
      BYTE_HEAD_HIT  = 2'd1,
      BYTE_HEAD_MISS = 2'd2,
      BYTE_TAIL      = 2'd3
   } byte_kind_e;

endpackage

// File: rtl/disp_ctl_seq.sv
module disp_ctl_seq
   import disp_ctl_pkg::*;
#(
   parameter int              ID_W   = 4,
   parameter logic [ID_W-1:0] CMD_ID = 4'hF
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            vld_i,
   input  logic [ID_W-1:0] id_i,
   output logic            head_load_o,
   output logic            tail_load_o
);

   generate
      if (CMD_ID[ID_W-1] != 1'b1) begin : g_bad_id
         $error("disp_ctl_seq: CMD_ID must have its top bit set");
      end
   endgenerate

   seq_state_e state_q, state_d;
   byte_kind_e kind;
   logic       id_hit;

   assign id_hit = (id_i == CMD_ID);

   always_comb begin
      if (!vld_i)             kind = BYTE_NONE;
      else if (!id_i[ID_W-1]) kind = BYTE_TAIL;
      else if (id_hit)        kind = BYTE_HEAD_HIT;
      else                    kind = BYTE_HEAD_MISS;
   end

   always_comb begin
      state_d = state_q;
      unique case (kind)
         BYTE_HEAD_HIT:  state_d = SEQ_WAIT2;
         BYTE_HEAD_MISS: state_d = SEQ_IDLE;
         BYTE_TAIL:      state_d = SEQ_IDLE;
         default:        state_d = state_q;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= SEQ_IDLE;
      else        state_q <= state_d;
   end

   assign head_load_o = (kind == BYTE_HEAD_HIT);
   assign tail_load_o = (kind == BYTE_TAIL) && (state_q == SEQ_WAIT2);

   assert_miss_cancels_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (vld_i && id_i[ID_W-1] && (id_i != CMD_ID)) |=> (state_q == SEQ_IDLE));

   assert_one_tail_R8: assert property (@(posedge clk) disable iff (!rst_n)
      tail_load_o |=> !tail_load_o);

   assert_idle_keeps_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !vld_i |=> $stable(state_q));

endmodule

// File: rtl/disp_ctl_pinsel.sv
module disp_ctl_pinsel #(
   parameter int NUM_PINS    = 2,
   parameter bit PIN_REG_OUT = 1'b0,
   localparam int CTRL_W     = 2 * NUM_PINS
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                load_i,
   input  logic [CTRL_W-1:0]   ctrl_i,
   input  logic [NUM_PINS-1:0] func_i,
   output logic [NUM_PINS-1:0] pin_o
);

   logic [CTRL_W-1:0] ctrl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ctrl_q <= '0;
      else if (load_i) ctrl_q <= ctrl_i;
   end

   generate
      for (genvar k = 0; k < NUM_PINS; k++) begin : g_pin
         logic sel, lvl, mux;
         assign sel = ctrl_q[2*k+1];
         assign lvl = ctrl_q[2*k];
         assign mux = sel ? lvl : func_i[k];

         if (PIN_REG_OUT) begin : g_reg
            logic pin_q;
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) pin_q <= 1'b0;
               else        pin_q <= mux;
            end
            assign pin_o[k] = pin_q;
         end else begin : g_comb
            assign pin_o[k] = mux;
         end
      end
   endgenerate

   assert_ctrl_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> (ctrl_q == $past(ctrl_i)));

   assert_ctrl_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !load_i |=> $stable(ctrl_q));

endmodule

// File: rtl/disp_ctl_setup.sv
module disp_ctl_setup #(
   parameter int SETUP_W = 5
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load_i,
   input  logic [SETUP_W-1:0] flags_i,
   output logic [SETUP_W-1:0] setup_o
);

   logic [SETUP_W-1:0] setup_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      setup_q <= '0;
      else if (load_i) setup_q <= flags_i;
   end

   assign setup_o = setup_q;

   assert_setup_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> (setup_q == $past(flags_i)));

   assert_setup_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !load_i |=> $stable(setup_q));

endmodule

// File: rtl/disp_ctl_cmd.sv
module disp_ctl_cmd #(
   parameter int              BYTE_W      = 8,
   parameter int              ID_W        = 4,
   parameter logic [ID_W-1:0] CMD_ID      = 4'hF,
   parameter int              NUM_PINS    = 2,
   parameter int              SETUP_W     = 5,
   parameter bit              PIN_REG_OUT = 1'b0,
   localparam int             CTRL_W      = 2 * NUM_PINS
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                byte_vld_i,
   input  logic [BYTE_W-1:0]   byte_i,
   input  logic [NUM_PINS-1:0] func_i,
   output logic [NUM_PINS-1:0] pin_o,
   output logic [SETUP_W-1:0]  setup_o
);

   generate
      if (ID_W + CTRL_W != BYTE_W) begin : g_bad_layout
         $error("disp_ctl_cmd: identifier plus pin controls must fill the byte");
      end
      if (SETUP_W >= BYTE_W || SETUP_W < 1) begin : g_bad_setup
         $error("disp_ctl_cmd: setup field must fit below the marker bit");
      end
   endgenerate

   logic            head_load, tail_load;
   logic [ID_W-1:0] id_field;
   logic            id_hit;

   assign id_field = byte_i[BYTE_W-1 -: ID_W];
   assign id_hit   = (id_field == CMD_ID);

   disp_ctl_seq #(
      .ID_W   (ID_W),
      .CMD_ID (CMD_ID)
   ) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .vld_i       (byte_vld_i),
      .id_i        (id_field),
      .head_load_o (head_load),
      .tail_load_o (tail_load)
   );

   disp_ctl_pinsel #(
      .NUM_PINS    (NUM_PINS),
      .PIN_REG_OUT (PIN_REG_OUT)
   ) u_pins (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (head_load),
      .ctrl_i (byte_i[CTRL_W-1:0]),
      .func_i (func_i),
      .pin_o  (pin_o)
   );

   disp_ctl_setup #(
      .SETUP_W (SETUP_W)
   ) u_setup (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_i  (tail_load),
      .flags_i (byte_i[SETUP_W-1:0]),
      .setup_o (setup_o)
   );

   assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (setup_o == '0));

   generate
      for (genvar k = 0; k < NUM_PINS; k++) begin : g_pin_chk
         if (!PIN_REG_OUT) begin : g_comb_chk
            assert_forced_level_R4: assert property (@(posedge clk) disable iff (!rst_n)
               (byte_vld_i && id_hit && byte_i[2*k+1]) |=> (pin_o[k] == $past(byte_i[2*k])));
            assert_follow_func_R3: assert property (@(posedge clk) disable iff (!rst_n)
               (byte_vld_i && id_hit && !byte_i[2*k+1]) |=> (pin_o[k] == func_i[k]));
         end else begin : g_reg_chk
            assert_reg_lag_R10: assert property (@(posedge clk) disable iff (!rst_n)
               $past(byte_vld_i && id_hit && byte_i[2*k+1]) |=> (pin_o[k] == $past(byte_i[2*k], 2)));
         end
      end
   endgenerate

endmodule

// File: tb/tb_disp_ctl_cmd.sv
module tb_disp_ctl_cmd;

   logic       clk = 1'b0;
   logic       rst_n = 1'b1;
   logic       vld = 1'b0;
   logic [7:0] byt = 8'h00;
   logic [1:0] func = 2'b10;
   logic [1:0] pin_c, pin_r;
   logic [4:0] set_c, set_r;

   int total = 0;
   int bad = 0;
   bit finished = 1'b0;
   string tag = "R1";

   always #10 clk = ~clk;

   disp_ctl_cmd #(.PIN_REG_OUT(1'b0)) dut (
      .clk(clk), .rst_n(rst_n), .byte_vld_i(vld), .byte_i(byt),
      .func_i(func), .pin_o(pin_c), .setup_o(set_c));

   disp_ctl_cmd #(.PIN_REG_OUT(1'b1)) dut_reg (
      .clk(clk), .rst_n(rst_n), .byte_vld_i(vld), .byte_i(byt),
      .func_i(func), .pin_o(pin_r), .setup_o(set_r));

   // reference model
   bit       m_pend;
   bit [3:0] m_ctrl;
   bit [4:0] m_setup;
   bit [1:0] m_pinr;

   function automatic bit [1:0] m_pins();
      bit [1:0] r;
      for (int k = 0; k < 2; k++)
         r[k] = m_ctrl[2*k+1] ? m_ctrl[2*k] : func[k];
      return r;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_pend = 0; m_ctrl = 0; m_setup = 0; m_pinr = 0;
      end else begin
         m_pinr = m_pins();
         if (vld) begin
            if (byt[7]) begin
               if (byt[7:4] == 4'hF) begin
                  m_ctrl = byt[3:0];
                  m_pend = 1;
               end else begin
                  m_pend = 0;
               end
            end else if (m_pend) begin
               m_setup = byt[4:0];
               m_pend = 0;
            end
         end
      end
   end

   task automatic chk(input string what, input int got, input int exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s %s: got %0h expected %0h", tag, what, got, exp);
      end
   endtask

   always @(negedge clk) begin
      if (!finished) begin
         chk("model pin comb", int'(pin_c), int'(m_pins()));
         chk("model pin reg R10", int'(pin_r), int'(m_pinr));
         chk("model setup comb", int'(set_c), int'(m_setup));
         chk("model setup reg", int'(set_r), int'(m_setup));
      end
   end

   task automatic put(input logic v, input logic [7:0] b);
      @(posedge clk); #2;
      vld = v; byt = b;
   endtask

   task automatic send(input logic [7:0] b);
      put(1'b1, b);
      put(1'b0, 8'h00);
   endtask

   initial begin
      #3 rst_n = 1'b0;
      tag = "R1";
      @(negedge clk);
      chk("reset pin", int'(pin_c), 2'b10);
      chk("reset setup", int'(set_c), 0);
      chk("reset reg pin", int'(pin_r), 0);
      @(posedge clk); #2 rst_n = 1'b1;

      tag = "R6";
      send(8'h1F);
      @(negedge clk);
      chk("stray tail setup", int'(set_c), 0);
      chk("stray tail pin", int'(pin_c), 2'b10);

      tag = "R3";
      put(1'b0, 8'h00); func = 2'b01;
      @(negedge clk);
      chk("follow func", int'(pin_c), 2'b01);

      tag = "R2";
      put(1'b1, 8'hFC);
      @(negedge clk);
      chk("before accept edge", int'(pin_c), 2'b01);
      put(1'b0, 8'h00);
      @(negedge clk);
      chk("after accept edge", int'(pin_c), 2'b11);
      tag = "R10";
      chk("reg pin lags", int'(pin_r), 2'b01);
      @(negedge clk);
      chk("reg pin caught up", int'(pin_r), 2'b11);

      tag = "R4";
      put(1'b0, 8'h00); func = 2'b10;
      @(negedge clk);
      chk("forced high func 10", int'(pin_c), 2'b10);
      put(1'b0, 8'h00); func = 2'b00;
      @(negedge clk);
      chk("forced high func 00", int'(pin_c), 2'b10);
      put(1'b0, 8'h00); func = 2'b01;
      @(negedge clk);
      chk("forced high func 01", int'(pin_c), 2'b11);

      tag = "R5";
      send(8'h6B);
      @(negedge clk);
      chk("tail loads low five bits", int'(set_c), 5'h0B);

      tag = "R8";
      send(8'h15);
      @(negedge clk);
      chk("second tail ignored", int'(set_c), 5'h0B);

      tag = "R7";
      send(8'hF3);
      @(negedge clk);
      chk("head F3 pins", int'(pin_c), 2'b01);
      send(8'hA5);
      @(negedge clk);
      chk("foreign head leaves pins", int'(pin_c), 2'b01);
      send(8'h07);
      @(negedge clk);
      chk("cancelled tail ignored", int'(set_c), 5'h0B);

      tag = "R9";
      send(8'hF0);
      for (int i = 0; i < 3; i++) put(1'b0, 8'h1C);
      @(negedge clk);
      chk("idle junk ignored", int'(set_c), 5'h0B);
      send(8'h12);
      @(negedge clk);
      chk("pending kept over gap", int'(set_c), 5'h12);

      tag = "R1";
      put(1'b0, 8'h00); func = 2'b11; rst_n = 1'b0;
      @(negedge clk);
      chk("mid reset setup", int'(set_c), 0);
      chk("mid reset pin", int'(pin_c), 2'b11);
      chk("mid reset reg pin", int'(pin_r), 0);
      @(posedge clk); #2 rst_n = 1'b1;

      tag = "R2 R3 R4 R5 R6 R7 R8 R9 R10 random";
      for (int i = 0; i < 600; i++) begin
         int unsigned r = $urandom;
         logic [7:0] b;
         case (r % 4)
            0: b = {4'hF, 4'(r >> 8)};
            1: b = {1'b1, 7'(r >> 8)};
            default: b = {1'b0, 7'(r >> 8)};
         endcase
         put(((r >> 20) % 3) != 0, b);
         func = 2'(r >> 24);
      end
      put(1'b0, 8'h00);
      @(negedge clk);
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (50000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         total++; bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule